// File: doc/BRIEF.md
# Parallel Receive Sample Packer

This block sits behind a parallel capture port and turns a stream of narrow samples into words for a memory-bound transfer stream. Every sample is first widened, by sign extension or by zero fill, to a target width that depends on both the configured sample length and on whether packing is enabled. The widened sample is then either sent on its own, as a 16-bit or 32-bit transfer, or merged with its neighbours into full 32-bit words.

With packing on, 8-bit samples fill a word four at a time. Samples of 10 to 16 bits fill a word two at a time. Samples of 18 or 24 bits are carried as three bytes each, so four of them fill exactly three words. A word-order control chooses whether the earliest data lands at the low or the high end of each word. A flush input emits a zero-padded partial word at the end of a frame. A synchronous clear discards any partial data. Configuration may only change while no partial data is held, which is the state after reset, clear or flush.

Top module: `rx_packer`

## Requirements
- R1: The length code selects the sample width: 0=8, 1=10, 2=12, 3=14, 4=16, 5=18, 6=24 bits, and 7 behaves as 24. Samples of 10, 12 or 14 bits are widened to 16 bits in both packing modes.
- R2: When sign_ext is 1, the widened bits copy the sample's top bit. When sign_ext is 0, they are zero.
- R3: With pack_en 0, each accepted sample produces exactly one transfer on the following clock. out_wide is 0 for codes 0 to 4 and 1 for codes 5 to 7. A narrow transfer carries its data in out_data[15:0] with bits 31:16 at zero.
- R4: With pack_en 0, 8-bit samples are widened to 16 bits, and 18-bit and 24-bit samples are widened to 32 bits.
- R5: With pack_en 1 and code 0, every four samples form one word. With msb_first 0, the first sample goes in bits 7:0. With msb_first 1, it goes in bits 31:24.
- R6: With pack_en 1 and codes 1 to 4, every two 16-bit widened samples form one word. The first sample goes in bits 15:0 when msb_first is 0, and in bits 31:16 when msb_first is 1.
- R7: With pack_en 1 and codes 5 to 7, each sample is widened to 24 bits and contributes three bytes to a byte stream, so every four samples yield exactly three words. With msb_first 0, each sample's low byte enters the stream first and stream byte 0 is word bits 7:0. With msb_first 1, the high byte enters first and stream byte 0 is word bits 31:24.
- R8: In three-byte packing, a four-phase sample counter tracks the residual byte count. Phases 0, 1, 2 and 3 hold 0, 3, 2 and 1 residual bytes, and the counter returns to phase 0 with no residue after every fourth sample.
- R9: flush, in a cycle with in_valid low, emits the held partial word with its unfilled bytes at zero on the next clock, and empties the packer. It emits nothing when no data is held. flush is ignored in a cycle where in_valid is high.
- R10: clear discards held data, returns the phase counter to 0 and emits nothing on the next clock. It takes priority over in_valid and flush.
- R11: Every transfer produced with pack_en 1 is 32 bits wide (out_wide 1), and a word appears on the clock after the sample that completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous discard of partial data |
| flush | input | 1 | Emit partial word, zero padded |
| len_code | input | 3 | Sample length code |
| pack_en | input | 1 | Packing enable |
| sign_ext | input | 1 | 1 = sign extend, 0 = zero fill |
| msb_first | input | 1 | Word order: first data at the high end |
| in_valid | input | 1 | Sample strobe |
| in_data | input | IN_W | Sample, right-aligned |
| out_valid | output | 1 | Transfer valid |
| out_data | output | 32 | Transfer data |
| out_wide | output | 1 | 1 = 32-bit transfer, 0 = 16-bit |

## Verification
The hardest state to reach from the ports is a three-byte stream stopped at each of its residual phases and then either flushed or cleared. In that state the padding and the position of the leftover bytes depend on both the phase and the word order. The stimulus runs 18-bit and 24-bit streams of one, two, three, five and more samples in both orders, ends each with a flush or a clear, and places flush pulses alongside valid samples. A behavioural byte-queue model predicts every output cycle.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        LEN_8  = 3'd0,
        LEN_10 = 3'd1,
        LEN_12 = 3'd2,
        LEN_14 = 3'd3,
        LEN_16 = 3'd4,
        LEN_18 = 3'd5,
        LEN_24 = 3'd6,
        LEN_24X = 3'd7
    } len_e;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
        logic              wide;
    } xfer_t;

    function automatic int unsigned len_bits(logic [2:0] code);
        case (code)
            LEN_8:   return 8;
            LEN_10:  return 10;
            LEN_12:  return 12;
            LEN_14:  return 14;
            LEN_16:  return 16;
            LEN_18:  return 18;
            default: return 24;
        endcase
    endfunction

    // bytes a sample occupies in the packed stream
    function automatic logic [1:0] stream_bytes(logic [2:0] code);
        if (code == LEN_8)       return 2'd1;
        else if (code <= LEN_16) return 2'd2;
        else                     return 2'd3;
    endfunction

    function automatic logic [WORD_W-1:0] order_word(logic [WORD_W-1:0] s, logic msb);
        return msb ? {s[7:0], s[15:8], s[23:16], s[31:24]} : s;
    endfunction

endpackage

// File: rtl/rxpk_extend.sv
module rxpk_extend
    import rxpk_pkg::*;
#(
    parameter int IN_W = 24
) (
    input  logic [IN_W-1:0]   smp,
    input  logic [2:0]        len_code,
    input  logic              sign_ext,
    output logic [WORD_W-1:0] ext
);
    int unsigned w;
    logic        top_bit;

    always_comb begin
        w       = len_bits(len_code);
        top_bit = smp[w-1];
        for (int i = 0; i < WORD_W; i++) begin
            if (i < int'(w) && i < IN_W) ext[i] = smp[i];
            else                         ext[i] = sign_ext & top_bit;
        end
    end
endmodule

// File: rtl/rxpk_core.sv
module rxpk_core
    import rxpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] ext,
    input  logic [2:0]        len_code,
    input  logic              pack_en,
    input  logic              msb_first,
    output xfer_t             xfer,
    output logic [1:0]        res_cnt,
    output logic [1:0]        phase
);
    localparam int RES_W = 24;
    localparam int STR_W = WORD_W + RES_W;

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic [1:0]       cnt;
        logic [1:0]       phase;
        xfer_t            out;
    } st_t;

    st_t cur_q, nxt_d;

    logic [1:0]       nb;
    logic [RES_W-1:0] sb;
    logic [STR_W-1:0] stream;
    logic [2:0]       total;
    logic             three;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.out = '0;
        nb        = stream_bytes(len_code);
        three     = (nb == 2'd3);
        sb        = '0;
        for (int i = 0; i < 3; i++) begin
            if (i < int'(nb)) begin
                if (msb_first) sb[8*i +: 8] = ext[8*(int'(nb) - 1 - i) +: 8];
                else           sb[8*i +: 8] = ext[8*i +: 8];
            end
        end
        stream = {{WORD_W{1'b0}}, cur_q.res} | ({{WORD_W{1'b0}}, sb} << {cur_q.cnt, 3'b000});
        total  = {1'b0, cur_q.cnt} + {1'b0, nb};

        if (clear) begin
            nxt_d.res   = '0;
            nxt_d.cnt   = '0;
            nxt_d.phase = '0;
        end else if (in_valid && !pack_en) begin
            nxt_d.out.vld  = 1'b1;
            nxt_d.out.wide = three;
            nxt_d.out.data = three ? ext : {16'b0, ext[15:0]};
        end else if (in_valid) begin
            if (three) nxt_d.phase = cur_q.phase + 2'd1;
            if (total >= 3'd4) begin
                nxt_d.out.vld  = 1'b1;
                nxt_d.out.wide = 1'b1;
                nxt_d.out.data = order_word(stream[WORD_W-1:0], msb_first);
                nxt_d.res      = stream[STR_W-1:WORD_W];
                nxt_d.cnt      = 2'(total - 3'd4);
            end else begin
                nxt_d.res = stream[RES_W-1:0];
                nxt_d.cnt = total[1:0];
            end
        end else if (flush) begin
            if (cur_q.cnt != 2'd0) begin
                nxt_d.out.vld  = 1'b1;
                nxt_d.out.wide = 1'b1;
                nxt_d.out.data = order_word({8'b0, cur_q.res}, msb_first);
            end
            nxt_d.res   = '0;
            nxt_d.cnt   = '0;
            nxt_d.phase = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign xfer    = cur_q.out;
    assign res_cnt = cur_q.cnt;
    assign phase   = cur_q.phase;
endmodule

// File: rtl/rx_packer.sv
module rx_packer
    import rxpk_pkg::*;
#(
    parameter int IN_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            flush,
    input  logic [2:0]      len_code,
    input  logic            pack_en,
    input  logic            sign_ext,
    input  logic            msb_first,
    input  logic            in_valid,
    input  logic [IN_W-1:0] in_data,
    output logic            out_valid,
    output logic [31:0]     out_data,
    output logic            out_wide
);
    logic [WORD_W-1:0] ext;
    xfer_t             xfer;
    logic [1:0]        res_cnt;
    logic [1:0]        phase;

    rxpk_extend #(.IN_W(IN_W)) u_ext (
        .smp      (in_data),
        .len_code (len_code),
        .sign_ext (sign_ext),
        .ext      (ext)
    );

    rxpk_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .flush     (flush),
        .in_valid  (in_valid),
        .ext       (ext),
        .len_code  (len_code),
        .pack_en   (pack_en),
        .msb_first (msb_first),
        .xfer      (xfer),
        .res_cnt   (res_cnt),
        .phase     (phase)
    );

    assign out_valid = xfer.vld;
    assign out_data  = xfer.data;
    assign out_wide  = xfer.wide;
endmodule

// File: rtl/rx_packer_chk.sv
module rx_packer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clear,
    input logic        flush,
    input logic [2:0]  len_code,
    input logic        pack_en,
    input logic        in_valid,
    input logic        out_valid,
    input logic [31:0] out_data,
    input logic        out_wide,
    input logic [1:0]  res_cnt,
    input logic [1:0]  phase
);
    a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_wide) |-> (out_data[31:16] == 16'h0));

    a_r3_one_per_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && in_valid && !pack_en) |=> out_valid);

    a_r8_phase_tracks_residue: assert property (@(posedge clk) disable iff (!rst_n)
        (pack_en && len_code >= 3'd5) |-> (res_cnt == 2'(2'd0 - phase)));

    a_r9_flush_emits: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && flush && !in_valid && res_cnt != 2'd0) |=> (out_valid && out_wide));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && flush && !in_valid) |=> (res_cnt == 2'd0 && phase == 2'd0));

    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (res_cnt == 2'd0 && phase == 2'd0 && !out_valid));

    a_r11_packed_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && pack_en) |=> (!out_valid || out_wide));
endmodule

bind rx_packer rx_packer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .flush     (flush),
    .len_code  (len_code),
    .pack_en   (pack_en),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_wide  (out_wide),
    .res_cnt   (res_cnt),
    .phase     (phase)
);

// File: tb/test_rx_packer.sv
`timescale 1ns/1ps
module test_rx_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0, flush = 1'b0, in_valid = 1'b0;
    logic [2:0]  len_code = 3'd0;
    logic        pack_en = 1'b0, sign_ext = 1'b0, msb_first = 1'b0;
    logic [23:0] in_data = '0;
    logic        out_valid, out_wide;
    logic [31:0] out_data;

    int checks = 0, errors = 0;
    byte unsigned q[$];

    always #10 clk = ~clk;

    rx_packer i_rx_packer (
        .clk(clk), .rst_n(rst_n), .clear(clear), .flush(flush),
        .len_code(len_code), .pack_en(pack_en), .sign_ext(sign_ext),
        .msb_first(msb_first), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_wide(out_wide)
    );

    function automatic int width_of(logic [2:0] c);
        int t [8] = '{8, 10, 12, 14, 16, 18, 24, 24};
        return t[c];
    endfunction

    function automatic longint widen(int w, longint v, bit s, int tw);
        longint x = v & ((64'd1 << w) - 1);
        if (s && x[w-1]) x = x - (64'd1 << w);
        return x & ((64'd1 << tw) - 1);
    endfunction

    function automatic longint take_word();
        longint r = 0;
        for (int k = 0; k < 4; k++) begin
            longint b = longint'(q.pop_front());
            r = r | (b << (msb_first ? 8 * (3 - k) : 8 * k));
        end
        return r;
    endfunction

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic step(bit v, logic [23:0] d, bit f, bit c, string tag);
        bit ev = 0, ew = 0;
        longint ed = 0;
        int w, nb;
        longint val;
        in_valid = v; in_data = d; flush = f; clear = c;
        w = width_of(len_code);
        if (c) q.delete();
        else if (v && !pack_en) begin
            ev = 1; ew = (w > 16);
            ed = widen(w, longint'(d), sign_ext, ew ? 32 : 16);
        end else if (v) begin
            nb  = (w == 8) ? 1 : (w <= 16 ? 2 : 3);
            val = (w == 8) ? longint'(d[7:0]) : widen(w, longint'(d), sign_ext, 8 * nb);
            for (int k = 0; k < nb; k++)
                q.push_back(byte'(val >> (msb_first ? 8 * (nb - 1 - k) : 8 * k)));
            if (q.size() >= 4) begin ev = 1; ew = 1; ed = take_word(); end
        end else if (f && q.size() > 0) begin
            while (q.size() < 4) q.push_back(8'h00);
            ev = 1; ew = 1; ed = take_word();
        end
        @(negedge clk);
        checks++;
        if (out_valid !== ev || (ev && (out_data !== 32'(ed) || out_wide !== ew))) begin
            errors++;
            $display("FAIL %s: valid=%0b data=%08h wide=%0b expected valid=%0b data=%08h wide=%0b",
                     tag, out_valid, out_data, out_wide, ev, 32'(ed), ew);
        end
    endtask

    task automatic idle(string tag);
        step(0, '0, 0, 0, tag);
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) step(1, 24'($urandom), 0, 0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: valid=%0b expected run to end", out_valid);
        report();
    end

    initial begin
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_data !== 32'h0) begin
            errors++;
            $display("FAIL R10 reset: valid=%0b data=%08h expected valid=0 data=0", out_valid, out_data);
        end
        rst_n = 1'b1;
        idle("R10 idle after reset");

        // R1 R2 R3 R4: unpacked, all codes, both fills, corner values
        pack_en = 0;
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < 2; s++) begin
                len_code = 3'(c); sign_ext = s[0];
                step(1, 24'hFFFFFF, 0, 0, "R2 all ones");
                step(1, 24'h000000, 0, 0, "R1 zero");
                step(1, 24'(64'd1 << (width_of(3'(c)) - 1)), 0, 0, "R2 top bit only");
                run(4, "R3 R4 unpacked");
                idle("R3 no sample no output");
            end
        end

        // R5: 8-bit packing, both orders
        pack_en = 1;
        for (int o = 0; o < 2; o++) begin
            msb_first = o[0]; len_code = 3'd0; sign_ext = 1;
            step(1, 24'h000011, 0, 0, "R5 byte0");
            step(1, 24'h000022, 0, 0, "R5 byte1");
            step(1, 24'h000033, 0, 0, "R5 byte2");
            step(1, 24'h0000C4, 0, 0, "R5 byte3");
            run(9, "R5 stream");
            step(0, '0, 1, 0, "R9 flush after 8-bit");
            idle("R9 flush once");
        end

        // R6: 10..16-bit packing
        for (int o = 0; o < 2; o++) begin
            msb_first = o[0];
            for (int c = 1; c < 5; c++) begin
                len_code = 3'(c); sign_ext = c[0];
                step(1, 24'hFFF800, 0, 0, "R6 negative");
                run(5, "R6 stream");
                step(0, '0, 1, 0, "R9 flush half word");
            end
        end

        // R7 R8 R9 R10: three-byte packing at each phase
        for (int o = 0; o < 2; o++) begin
            msb_first = o[0];
            for (int c = 5; c < 8; c++) begin
                len_code = 3'(c);
                for (int n = 1; n < 10; n++) begin
                    sign_ext = n[0];
                    run(n, "R7 R8 three byte");
                    if (n % 3 == 0) step(0, '0, 0, 1, "R10 clear mid frame");
                    else            step(0, '0, 1, 0, "R9 flush partial");
                    step(0, '0, 1, 0, "R9 flush when empty");
                end
                run(2, "R7 before flush-with-valid");
                step(1, 24'h123456, 1, 0, "R9 flush ignored with valid");
                step(1, 24'h800001, 1, 1, "R10 clear beats valid");
                run(4, "R8 back at phase zero");
                idle("R8 nothing held");
                step(0, '0, 1, 0, "R8 flush emits nothing");
            end
        end

        // R11: long packed stream with gaps
        len_code = 3'd6; msb_first = 0;
        for (int i = 0; i < 40; i++) begin
            if (i % 5 == 2) idle("R11 gap");
            else            run(1, "R11 packed wide");
        end
        step(0, '0, 1, 0, "R11 final flush");
        report();
    end
endmodule